// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns the system clock into the oversampling enable that a serial transmitter and receiver step on. A scale word sets the period as a fixed-point divisor. The low six bits hold a fraction in steps of 1/64, and the bits above them hold the whole number of system clocks. The two outputs are a one-clock oversample tick and a bit tick. The bit tick marks every 16th oversample tick, or every 8th one when the half-rate option is picked.

The divisor is meant to be f_sys / (baud x M), with M equal to 16 or 8. The fraction is that divisor's fractional part times 64, rounded to the nearest step. Each oversample period lasts either the integer part or the integer part plus one clock. A six-bit accumulator sums the fraction once per tick and adds one clock to the next period whenever it carries, so the average period matches the programmed value. A load strobe latches a new scale word and mode and restarts the division from a clean state. Out of reset the block runs at 115200 baud with 16x oversampling for the configured system clock.

Top module: `baud_tick_gen`

## Requirements
- R1: Out of reset the scale equals round(SYS_CLK_HZ*64 / (RESET_BAUD*16)), which is integer 27 and fraction 8 at the defaults, with 16x mode. Both outputs are low while rstN is low. Counting the first clock after the release as cycle 1, the first oversample tick is in cycle 27.
- R2: scaleWord[5:0] is the fraction and scaleWord[SCALE_W-1:6] is the integer part. scaleWord and halfRate are taken only in a cycle where cfgLoad is high. Changing them in any other cycle leaves both outputs unchanged.
- R3: A load restarts the period counter, the fraction accumulator and the oversample count, even in the middle of a period. Counting the first cycle after the load cycle as cycle 1, the first tick is in cycle I, where I is the integer part.
- R4: Tick k after a restart falls in cycle k*I + floor((k-1)*F/64), where F is the fraction. Each period is therefore I or I+1 clocks.
- R5: Each oversample tick is high for one clock. With I=1 and F=0 it is high in every cycle.
- R6: While the loaded integer part is 0, neither ovsTick nor bitTick is ever asserted.
- R7: halfRate=1 at load selects 8 oversample ticks per bit, and halfRate=0 selects 16. bitTick is high together with the M-th, 2M-th, ... oversample tick after a restart.
- R8: The largest integer part, 2^(SCALE_W-6)-1, with fraction 63 gives periods of I or I+1 clocks with no counter wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Latch scaleWord and halfRate and restart the divider |
| scaleWord | input | SCALE_W | Integer part in [SCALE_W-1:6], fraction in [5:0] |
| halfRate | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| ovsTick | output | 1 | One-clock oversample enable |
| bitTick | output | 1 | One-clock bit-period enable |

## Verification
The outputs are decoded from registers, so a load that is sampled at one edge sets the timing from the next cycle on. The first tick falls I cycles after the load cycle, and tick k falls k*I + floor((k-1)*F/64) cycles after it. bitTick falls in the same cycle as every M-th of those ticks. The bench drives its inputs on falling edges and compares both outputs on every falling edge against a closed-form tick schedule. That schedule restarts from cycle 1 on the first falling edge after each load or reset release, so each result is compared in exactly the cycle it is due.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  localparam int FRAC_W = 6;

  typedef struct packed {
    logic restart;
    logic run;
  } tick_strobes_t;
endpackage

// File: rtl/baud_tick_dp.sv
module baud_tick_dp
  import baud_tick_pkg::*;
#(
  parameter int INT_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  tick_strobes_t       strobes,
  input  logic [INT_W-1:0]    cfgInt,
  input  logic [FRAC_W-1:0]   cfgFrac,
  output logic                ovsTick
);
  logic [INT_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic              ext;
  logic [INT_W:0]    lastIdx;
  logic [FRAC_W:0]   accSum;

  assign lastIdx = {1'b0, cfgInt} - (INT_W+1)'(1) + (INT_W+1)'(ext);
  assign accSum  = {1'b0, acc} + {1'b0, cfgFrac};
  assign ovsTick = strobes.run && ({1'b0, cnt} == lastIdx);

  always_ff @(posedge clk) begin
    if (!rstN || strobes.restart) begin
      cnt <= '0;
      acc <= '0;
      ext <= 1'b0;
    end else if (ovsTick) begin
      cnt <= '0;
      acc <= accSum[FRAC_W-1:0];
      ext <= accSum[FRAC_W];
    end else if (strobes.run) begin
      cnt <= cnt + INT_W'(1);
    end
  end

  AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restart |=> (cnt == '0 && acc == '0)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, cnt} <= {1'b0, cfgInt} || cfgInt == '0); // R8
  AST_SINGLE_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    (ovsTick && !strobes.restart && cfgInt > INT_W'(1)) |=> !ovsTick); // R5
endmodule

// File: rtl/baud_tick_ctrl.sv
module baud_tick_ctrl
  import baud_tick_pkg::*;
#(
  parameter int SCALE_W   = 18,
  parameter int OVS_HI    = 16,
  parameter int OVS_LO    = 8,
  parameter int DEF_SCALE = 1736,
  localparam int INT_W    = SCALE_W - FRAC_W,
  localparam int OVS_W    = $clog2(OVS_HI)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgLoad,
  input  logic [SCALE_W-1:0]  scaleWord,
  input  logic                halfRate,
  input  logic                ovsTick,
  output tick_strobes_t       strobes,
  output logic [INT_W-1:0]    cfgInt,
  output logic [FRAC_W-1:0]   cfgFrac,
  output logic                bitTick
);
  localparam logic [SCALE_W-1:0] DEF_WORD = SCALE_W'(DEF_SCALE);

  logic             cfgHalf;
  logic [OVS_W-1:0] ovsCnt;
  logic [OVS_W-1:0] lastOvs;

  assign lastOvs         = cfgHalf ? OVS_W'(OVS_LO - 1) : OVS_W'(OVS_HI - 1);
  assign strobes.restart = cfgLoad;
  assign strobes.run     = (cfgInt != '0);
  assign bitTick         = ovsTick && (ovsCnt == lastOvs);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgInt  <= DEF_WORD[SCALE_W-1:FRAC_W];
      cfgFrac <= DEF_WORD[FRAC_W-1:0];
      cfgHalf <= 1'b0;
    end else if (cfgLoad) begin
      cfgInt  <= scaleWord[SCALE_W-1:FRAC_W];
      cfgFrac <= scaleWord[FRAC_W-1:0];
      cfgHalf <= halfRate;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || cfgLoad) begin
      ovsCnt <= '0;
    end else if (ovsTick) begin
      ovsCnt <= (ovsCnt == lastOvs) ? '0 : ovsCnt + OVS_W'(1);
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cfgInt == '0) |-> (!ovsTick && !bitTick)); // R6
  AST_OVS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ovsCnt <= lastOvs); // R7
  AST_BIT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (bitTick && !cfgLoad) |=> (ovsCnt == '0)); // R7
  AST_HOLD_CFG: assert property (@(posedge clk) disable iff (!rstN)
    !cfgLoad |=> ($stable(cfgInt) && $stable(cfgFrac) && $stable(cfgHalf))); // R2
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int SYS_CLK_HZ = 50_000_000,
  parameter int RESET_BAUD = 115_200,
  parameter int SCALE_W    = 18
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgLoad,
  input  logic [SCALE_W-1:0] scaleWord,
  input  logic               halfRate,
  output logic               ovsTick,
  output logic               bitTick
);
  localparam int OVS_HI = 16;
  localparam int OVS_LO = 8;
  localparam int INT_W  = SCALE_W - FRAC_W;
  localparam longint unsigned DEN  = 64'(RESET_BAUD) * 64'(OVS_HI);
  localparam longint unsigned NUM  = 64'(SYS_CLK_HZ) * 64'(1 << FRAC_W);
  localparam int DEF_SCALE = int'((NUM + DEN / 2) / DEN);

  tick_strobes_t     strobes;
  logic [INT_W-1:0]  cfgInt;
  logic [FRAC_W-1:0] cfgFrac;

  baud_tick_ctrl #(
    .SCALE_W  (SCALE_W),
    .OVS_HI   (OVS_HI),
    .OVS_LO   (OVS_LO),
    .DEF_SCALE(DEF_SCALE)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgLoad  (cfgLoad),
    .scaleWord(scaleWord),
    .halfRate (halfRate),
    .ovsTick  (ovsTick),
    .strobes  (strobes),
    .cfgInt   (cfgInt),
    .cfgFrac  (cfgFrac),
    .bitTick  (bitTick)
  );

  baud_tick_dp #(
    .INT_W(INT_W)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .cfgInt (cfgInt),
    .cfgFrac(cfgFrac),
    .ovsTick(ovsTick)
  );
endmodule

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;
  localparam int SCALE_W = 18;
  localparam int MAX_INT = (1 << (SCALE_W - 6)) - 1;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               cfgLoad = 1'b0;
  logic [SCALE_W-1:0] scaleWord = '0;
  logic               halfRate = 1'b0;
  logic               ovsTick, bitTick;

  int vecs = 0;
  int errs = 0;
  int mI, mF, mM;
  int c, k, nt;
  string tag = "R1";

  always #2.5 clk = ~clk;

  baud_tick_gen #(.SCALE_W(SCALE_W)) dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .scaleWord(scaleWord),
    .halfRate(halfRate), .ovsTick(ovsTick), .bitTick(bitTick)
  );

  function automatic int dueCycle(int idx, int ip, int fp);
    return idx * ip + ((idx - 1) * fp) / 64;
  endfunction

  task automatic compare(logic expOvs, logic expBit);
    vecs++;
    if (ovsTick !== expOvs || bitTick !== expBit) begin
      errs++;
      $display("FAIL %s cycle %0d: ovsTick=%0b bitTick=%0b expected %0b %0b",
               tag, c, ovsTick, bitTick, expOvs, expBit);
    end
  endtask

  task automatic step();
    logic eo, eb;
    @(negedge clk);
    c++;
    eo = (mI != 0) && (c == dueCycle(k, mI, mF));
    eb = 1'b0;
    if (eo) begin
      nt++;
      eb = ((nt % mM) == 0);
      k++;
    end
    compare(eo, eb);
  endtask

  task automatic runFor(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic loadCfg(int ip, int fp, bit half);
    scaleWord = SCALE_W'((ip << 6) | fp);
    halfRate  = half;
    cfgLoad   = 1'b1;
    mI = ip; mF = fp; mM = half ? 8 : 16;
    c = 0; k = 1; nt = 0;
    step();
    cfgLoad = 1'b0;
  endtask

  initial begin
    #(5ns * 200000);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      c = 0;
      compare(1'b0, 1'b0);
    end
    rstN = 1'b1;
    mI = 27; mF = 8; mM = 16; c = 1; k = 1; nt = 0;
    tag = "R1";
    runFor(1000);

    tag = "R5"; loadCfg(1, 0, 1'b0); runFor(100);
    tag = "R7"; loadCfg(1, 0, 1'b1); runFor(100);
    tag = "R4"; loadCfg(1, 63, 1'b0); runFor(300);
    tag = "R4"; loadCfg(2, 32, 1'b0); runFor(300);
    tag = "R6"; loadCfg(0, 17, 1'b0); runFor(200);
    tag = "R3"; loadCfg(5, 21, 1'b1); runFor(13);
    tag = "R3"; loadCfg(5, 21, 1'b1); runFor(200);
    // R2: config inputs change without a load
    tag = "R2"; loadCfg(9, 40, 1'b0); runFor(50);
    scaleWord = SCALE_W'((3 << 6) | 5);
    halfRate  = 1'b1;
    runFor(400);
    tag = "R8"; loadCfg(MAX_INT, 63, 1'b1); runFor(8 * (MAX_INT + 1) + 50);

    tag = "R4";
    for (int j = 0; j < 24; j++) begin
      int ip;
      ip = (($urandom % 8) == 0) ? 0 : 1 + int'($urandom % 40);
      loadCfg(ip, int'($urandom % 64), bit'($urandom % 2));
      runFor(100 + int'($urandom % 1200));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule